// File: doc/BRIEF.md
# Configuration Register Access Decoder

This block sits between a processor bus and a small bank of 32-bit configuration registers. It decides whether a bus access belongs to the register bank, and which register and byte lanes it reaches. It then performs the read or the masked write and returns a one-cycle-late response.

Two address maps are offered. In the direct map, each register sits at its own address inside a fixed 256-byte region. In the indirect map, software first stores a pointer word into an address port. After that, a four-byte data window reaches whichever register the pointer names. The indirect port and window can be placed at either of two address pairs, chosen by a placement input. Registers hold their bytes little-endian. A per-register parameter mask protects read-only and reserved bits from writes.

Top module: `cfg_access_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0, the pointer is invalid with offset 0, and every register holds its parameter reset value (defaults: A8=FFFFFFFF, AC=12340000, B0=00000000, B4=CAFE0001).
- R2: In the indirect map, a word write to the address port stores bits 7:0 as the register offset. It marks the pointer valid only when bits 31:8 equal 0x800000. A word read of the port returns {0x800000 if valid else 0x000000, offset}. A non-word access to the port is not claimed.
- R3: With `discontig`=0 the address port is 0x80000CF8 and the window is 0x80000CFC..CFF. With `discontig`=1 they are 0x80067018 and 0x8006701C..701F, and the other pair is not claimed.
- R4: A window access with a valid pointer reaches the register at the pointer offset. A read returns the full 32-bit register. A write response returns data 0.
- R5: Size codes are 0=byte, 1=halfword, 2=word. A write changes only the lanes chosen by the size and the low two address bits. Byte offset k corresponds to register bits 8k+7:8k and `req_wdata` bits 8k+7:8k.
- R6: A halfword access at an odd address, a word access whose address is not a multiple of 4, or size code 3 is not claimed, and it changes no register.
- R7: With `map_direct`=1, address 0xF8FFF0nn reaches offset nn directly. An offset outside the bank is claimed, reads 0 and ignores writes.
- R8: A window access while the pointer is invalid is claimed. A read returns 0xFFFFFFFF and a write changes nothing.
- R9: A write changes only the bits set in that register's writable mask (defaults: A8 all, AC bits 15:0, B0 bits 23:16 and 7:0, B4 none).
- R10: An access matching no decoded address of the selected map gives `rsp_nohit`=1 with data 0 and no state change.
- R11: Every request produces exactly one response, with `rsp_valid` high in the cycle after the request. `rsp_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| map_direct | input | 1 | 1 selects the direct map, 0 the indirect map |
| discontig | input | 1 | 1 selects the alternate indirect placement |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, lane k on bits 8k+7:8k |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_nohit | output | 1 | Request was not claimed |
| rsp_rdata | output | 32 | Read data |

## Verification
A stale or corrupted pointer shows up on the very next window access. It appears either as the wrong register's contents, or as all ones where a valid register was expected. Reading the address port exposes the latched offset in the following cycle. A lane-steering or mask fault shows up only when the affected register is next read back, so every write is followed immediately by a read through either map. Decode faults appear in the same response as the faulty request, as a wrong `rsp_nohit` flag.

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder #(
  parameter int NREG = 4,
  parameter logic [7:0] BASE_OFF = 8'hA8,
  parameter logic [NREG*32-1:0] WMASK  = {32'h0000_0000, 32'h00FF_00FF, 32'h0000_FFFF, 32'hFFFF_FFFF},
  parameter logic [NREG*32-1:0] RSTVAL = {32'hCAFE_0001, 32'h0000_0000, 32'h1234_0000, 32'hFFFF_FFFF}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        map_direct,
  input  logic        discontig,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_nohit,
  output logic [31:0] rsp_rdata
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [23:0] PTR_TAG = 24'h80_0000;
  localparam logic [23:0] DIR_TAG = 24'hF8_FFF0;

  logic [31:0]        bank [NREG];
  logic [NREG*32-1:0] bank_flat;
  logic [7:0]         ptr_off;
  logic               ptr_ok;
  logic [3:0]         be;

  wire [31:0] port_a  = discontig ? 32'h8006_7018 : 32'h8000_0CF8;
  wire [29:0] win_w   = port_a[31:2] + 30'd1;
  wire        aligned = (req_size == 2'd0) ||
                        (req_size == 2'd1 && !req_addr[0]) ||
                        (req_size == 2'd2 && req_addr[1:0] == 2'b00);
  wire hit_port = !map_direct && req_addr == port_a && req_size == 2'd2;
  wire hit_win  = !map_direct && req_addr[31:2] == win_w && aligned;
  wire hit_dir  = map_direct && req_addr[31:8] == DIR_TAG && aligned;
  wire hit      = hit_port || hit_win || hit_dir;

  wire [7:0]    off     = hit_dir ? req_addr[7:0] : ptr_off;
  wire [5:0]    rel     = off[7:2] - BASE_OFF[7:2];
  wire          in_bank = 32'(rel) < NREG;
  wire [IW-1:0] idx     = rel[IW-1:0];
  wire          reg_ok  = in_bank && (hit_dir || (hit_win && ptr_ok));
  wire [31:0]   lane_m  = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

  always_comb begin
    case (req_size)
      2'd0:    be = 4'b0001 << req_addr[1:0];
      2'd1:    be = 4'b0011 << req_addr[1:0];
      default: be = 4'b1111;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    wire [31:0] wm = lane_m & WMASK[i*32 +: 32];
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[i] <= RSTVAL[i*32 +: 32];
      else if (req_valid && req_write && reg_ok && idx == IW'(i))
        bank[i] <= (bank[i] & ~wm) | (req_wdata & wm);
    end
    assign bank_flat[i*32 +: 32] = bank[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_off <= 8'h00;
      ptr_ok  <= 1'b0;
    end else if (req_valid && req_write && hit_port) begin
      ptr_off <= req_wdata[7:0];
      ptr_ok  <= req_wdata[31:8] == PTR_TAG;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_nohit <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_nohit <= req_valid && !hit;
      if (!req_valid || req_write || !hit)
        rsp_rdata <= '0;
      else if (hit_port)
        rsp_rdata <= {ptr_ok ? PTR_TAG : 24'h0, ptr_off};
      else if (hit_win && !ptr_ok)
        rsp_rdata <= '1;
      else if (reg_ok)
        rsp_rdata <= bank[idx];
      else
        rsp_rdata <= '0;
    end
  end

  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_nohit_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nohit) |-> rsp_rdata == 32'h0);
  p_nohit_keeps_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |=> $stable(bank_flat) && $stable(ptr_off));
  p_bad_ptr_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && hit_win && !ptr_ok) |=> rsp_rdata == 32'hFFFF_FFFF);
  p_bad_ptr_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_win && !ptr_ok) |=> $stable(bank_flat));
  p_ptr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && hit_port) |=>
      (rsp_rdata[31:8] == PTR_TAG || rsp_rdata[31:8] == 24'h0));
endmodule

// File: tb/sim_cfg_access_decoder.sv
module sim_cfg_access_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_direct = 1'b0, discontig = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = 2'd0;
  logic        rsp_valid, rsp_nohit;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  logic [31:0] q_rd[$];
  logic        q_nh[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  cfg_access_decoder u0 (.clk(clk), .rst_n(rst_n), .map_direct(map_direct),
    .discontig(discontig), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_nohit(rsp_nohit), .rsp_rdata(rsp_rdata));

  task automatic acc(input logic w, input logic [31:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic [31:0] er, input logic en,
                     input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    q_rd.push_back(er); q_nh.push_back(en); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_rd.size() == 0) begin
        errors++;
        $display("FAIL R11: response with no request, actual valid=1 expected 0");
      end else begin
        logic [31:0] er; logic en; string t;
        er = q_rd.pop_front(); en = q_nh.pop_front(); t = q_tag.pop_front();
        if (rsp_rdata !== er || rsp_nohit !== en) begin
          errors++;
          $display("FAIL %s: actual data=%h nohit=%b expected data=%h nohit=%b",
                   t, rsp_rdata, rsp_nohit, er, en);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual run still going, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] PC = 32'h8000_0CF8, WC = 32'h8000_0CFC;
  localparam logic [31:0] PD = 32'h8006_7018, WD = 32'h8006_701C;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rsp_valid in reset actual %b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    acc(0, WC, 2, 0, 32'hFFFF_FFFF, 0, "R8 read, invalid pointer");
    acc(0, PC, 2, 0, 32'h0000_0000, 0, "R1 pointer reset");
    acc(0, PC, 0, 0, 32'h0, 1, "R2 byte access to port");
    acc(1, PC, 2, 32'h8000_00A8, 0, 0, "R2 pointer write");
    acc(0, PC, 2, 0, 32'h8000_00A8, 0, "R2 pointer readback");
    acc(0, WC, 2, 0, 32'hFFFF_FFFF, 0, "R1 reg A8 reset");
    acc(1, WC, 2, 32'hAABB_CCDD, 0, 0, "R4 word write");
    acc(0, WC, 2, 0, 32'hAABB_CCDD, 0, "R4 word readback");
    acc(1, WC + 2, 0, 32'h0011_0000, 0, 0, "R5 byte write lane2");
    acc(0, WC, 0, 0, 32'hAA11_CCDD, 0, "R5 byte lane readback");
    acc(1, WC + 2, 1, 32'h5566_0000, 0, 0, "R5 halfword upper");
    acc(0, WC + 3, 0, 0, 32'h5566_CCDD, 0, "R5 halfword readback");
    acc(1, WC + 1, 1, 32'h0000_0000, 0, 1, "R6 odd halfword");
    acc(1, WC + 1, 2, 32'h0000_0000, 0, 1, "R6 misaligned word");
    acc(1, WC, 3, 32'h0000_0000, 0, 1, "R6 size code 3");
    acc(0, WC, 2, 0, 32'h5566_CCDD, 0, "R6 unchanged after rejects");
    acc(0, 32'hF8FF_F0A8, 2, 0, 0, 1, "R10 direct address in indirect map");
    acc(1, 32'hF8FF_F0A8, 2, 0, 0, 1, "R10 direct write in indirect map");
    acc(0, WC, 2, 0, 32'h5566_CCDD, 0, "R10 no state change");
    acc(1, PC, 2, 32'h8000_00AC, 0, 0, "R2 pointer to AC");
    acc(1, WC, 2, 32'hFFFF_FFFF, 0, 0, "R9 masked write AC");
    acc(0, WC, 2, 0, 32'h1234_FFFF, 0, "R9 read-only bits kept");
    acc(1, PC, 2, 32'h1200_00AC, 0, 0, "R8 bad pointer write");
    acc(0, PC, 2, 0, 32'h0000_00AC, 0, "R2 invalid readback");
    acc(1, WC, 2, 32'h0000_0000, 0, 0, "R8 write ignored");
    acc(0, WC, 2, 0, 32'hFFFF_FFFF, 0, "R8 ones on read");
    idle();
    discontig = 1'b1;
    acc(0, PC, 2, 0, 0, 1, "R3 contiguous port unclaimed");
    acc(0, WC, 2, 0, 0, 1, "R3 contiguous window unclaimed");
    acc(1, PD, 2, 32'h8000_00B0, 0, 0, "R3 alternate port write");
    acc(0, WD, 2, 0, 32'h0000_0000, 0, "R3 reg B0 reset");
    acc(1, WD, 2, 32'hFFFF_FFFF, 0, 0, "R9 masked write B0");
    acc(0, WD, 2, 0, 32'h00FF_00FF, 0, "R9 B0 mask");
    idle();
    discontig = 1'b0; map_direct = 1'b1;
    acc(0, 32'hF8FF_F0AC, 2, 0, 32'h1234_FFFF, 0, "R8 earlier write had no effect");
    acc(0, 32'hF8FF_F0B4, 2, 0, 32'hCAFE_0001, 0, "R7 direct read B4");
    acc(1, 32'hF8FF_F0B4, 2, 32'h0000_0000, 0, 0, "R9 fully read-only write");
    acc(0, 32'hF8FF_F0B4, 2, 0, 32'hCAFE_0001, 0, "R9 B4 unchanged");
    acc(1, 32'hF8FF_F0A9, 0, 32'h0000_7700, 0, 0, "R7 direct byte write");
    acc(0, 32'hF8FF_F0A8, 2, 0, 32'h5566_77DD, 0, "R5 direct lane1");
    acc(0, PC, 2, 0, 0, 1, "R10 port in direct map");
    acc(1, 32'hF8FF_F010, 2, 32'h1234_5678, 0, 0, "R7 out-of-bank write");
    acc(0, 32'hF8FF_F010, 2, 0, 0, 0, "R7 out-of-bank read");
    acc(0, 32'hF8FE_F0A8, 2, 0, 0, 1, "R10 outside region");
    idle();
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || q_rd.size() != 0) begin
      errors++;
      $display("FAIL R11: idle actual valid=%b pending=%0d expected 0/0",
               rsp_valid, q_rd.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule